// File: doc/BRIEF.md
# Ternary Entry Write and Learn Controller

This block sits in front of a ternary match array and turns single-cycle commands into row writes, reads, deletes and searches. A write takes its row address either from the command bus or from an address register that remembers the row of the most recent search hit. It takes its data from the bus, from a one-deep register that holds a missed search key, or from a load register used to move entries. A write mask register decides which bits take the new value; masked bits keep what was stored. In paired mode one command writes the same row offset in both halves of the array, ignoring the half-select address bit.

The block also runs the learn procedure. A search that misses parks its key in the holding register and raises a full flag, and further searches are refused while that flag is up. A learn command then looks for the lowest empty row (flag bit, the top data bit, equal to 0), records that row in the address register and writes the parked key there. If no row is empty it gives up, raises a table-full status and leaves the array alone. The array itself is a plain behavioural row memory reset to all zeros, which is also the empty encoding.

Top module: `cam_write_learn`

## Requirements
- R1: A write command (op 1) with bus address and bus data (dsrc 0) stores cmd_data at cmd_addr; a read command (op 2) returns the row on rd_data with rd_valid high in the cycle after it is accepted.
- R2: With cmd_asrc high, a write goes to the row held in the address register, which a search hit loads with the lowest matching row index.
- R3: A mask-load command (op 7) loads the write mask from cmd_data (reset value all ones); on every write, bits with mask 1 take the new value and bits with mask 0 keep the old stored value.
- R4: With cmd_pair high, a write updates row {0,addr[AW-2:0]} and row {1,addr[AW-2:0]} in the same cycle under the shared mask; cmd_addr's top bit has no effect.
- R5: A search (op 5) compares cmd_data with every row on the bits where srch_mask is 1; one cycle later srch_done is high, srch_hit tells whether a row matched and srch_addr gives the lowest matching row.
- R6: A load command (op 3) copies a row into the load register, and a write with dsrc 2 writes that register's value.
- R7: A delete command (op 4) sets every bit of the addressed row to 0 regardless of the write mask.
- R8: A search that misses stores its key in the holding register and sets dsr_full; a write with dsrc 1 writes the held key.
- R9: While dsr_full is high a search command is refused: srch_done stays low and the address register keeps its value.
- R10: A learn command (op 6) accepted while dsr_full is high drops cmd_ready for two cycles, writes the held key to the lowest row whose top bit is 0, records that row in the address register, clears dsr_full and pulses learn_done.
- R11: If no row has its top bit at 0, a learn ends after one busy cycle with table_full set, dsr_full still set and the array unchanged; a later learn clears table_full when it starts.
- R12: After reset cmd_ready is high, dsr_full, table_full, rd_valid, srch_done and learn_done are low, and all rows read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 0 idle, 1 write, 2 read, 3 load, 4 delete, 5 search, 6 learn, 7 mask load |
| cmd_addr | input | AW | Row address from the bus |
| cmd_data | input | W | Write data, search key or mask value |
| cmd_asrc | input | 1 | Write address source: 0 bus, 1 address register |
| cmd_dsrc | input | 2 | Write data source: 0 bus, 1 held miss key, 2 load register |
| cmd_pair | input | 1 | Write both array halves at once |
| srch_mask | input | W | Per-bit search compare enable |
| cmd_ready | output | 1 | High when a command can be accepted |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | W | Read data |
| srch_done | output | 1 | Search result valid |
| srch_hit | output | 1 | Search matched a row |
| srch_addr | output | AW | Lowest matching row |
| dsr_full | output | 1 | Held miss key present |
| table_full | output | 1 | Last learn found no empty row |
| learn_done | output | 1 | Learn write finished |

## Verification
The paired write is the place where two row updates share one cycle and one mask: both halves are merged against their own old contents in the same edge. The bench provokes it by loading different values into the two halves first, then issuing a paired write under a partial mask, and judges it by reading each half back and comparing against the merge worked out by hand. A second overlap is the miss capture and the refusal of searching: a missed search raises the full flag on the same edge it parks the key, so the very next search is expected to produce no result and leave the address register where the earlier hit put it, which a write through that register then exposes.

// File: rtl/cam_write_learn.sv
module cam_write_learn #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [W-1:0]  cmd_data,
  input  logic          cmd_asrc,
  input  logic [1:0]    cmd_dsrc,
  input  logic          cmd_pair,
  input  logic [W-1:0]  srch_mask,
  output logic          cmd_ready,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic          srch_done,
  output logic          srch_hit,
  output logic [AW-1:0] srch_addr,
  output logic          dsr_full,
  output logic          table_full,
  output logic          learn_done
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] OP_WRITE = 3'd1, OP_READ = 3'd2, OP_LOAD = 3'd3,
                         OP_DELETE = 3'd4, OP_SEARCH = 3'd5, OP_LEARN = 3'd6,
                         OP_SETWM = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_FIND, S_WRITE} st_t;

  st_t           st;
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  wmask, dsr, ldr, wd;
  logic [AW-1:0] asr, wa, wa_lo, wa_hi, hit_idx, emp_idx;
  logic          hit_any, emp_any;

  assign cmd_ready = (st == S_IDLE);
  wire go = cmd_valid & cmd_ready;

  assign wa    = cmd_asrc ? asr : cmd_addr;
  assign wa_lo = {1'b0, wa[AW-2:0]};
  assign wa_hi = {1'b1, wa[AW-2:0]};

  always_comb begin
    case (cmd_dsrc)
      2'd1:    wd = dsr;
      2'd2:    wd = ldr;
      default: wd = cmd_data;
    endcase
  end

  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    emp_any = 1'b0; emp_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (((mem[i] ^ cmd_data) & srch_mask) == '0) begin
        hit_any = 1'b1; hit_idx = AW'(i);
      end
      if (!mem[i][W-1]) begin
        emp_any = 1'b1; emp_idx = AW'(i);
      end
    end
  end

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v, input logic [W-1:0] new_v);
    return (old_v & ~wmask) | (new_v & wmask);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wmask <= '1; dsr <= '0; ldr <= '0; asr <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
      srch_done <= 1'b0; srch_hit <= 1'b0; srch_addr <= '0;
      dsr_full <= 1'b0; table_full <= 1'b0; learn_done <= 1'b0;
    end else begin
      rd_valid <= 1'b0; srch_done <= 1'b0; learn_done <= 1'b0;
      case (st)
        S_FIND: begin
          if (emp_any) begin
            asr <= emp_idx;
            st  <= S_WRITE;
          end else begin
            table_full <= 1'b1;
            st         <= S_IDLE;
          end
        end
        S_WRITE: begin
          mem[asr]   <= merge(mem[asr], dsr);
          dsr_full   <= 1'b0;
          learn_done <= 1'b1;
          st         <= S_IDLE;
        end
        default: begin
          if (go) begin
            case (cmd_op)
              OP_WRITE: begin
                if (cmd_pair) begin
                  mem[wa_lo] <= merge(mem[wa_lo], wd);
                  mem[wa_hi] <= merge(mem[wa_hi], wd);
                end else begin
                  mem[wa] <= merge(mem[wa], wd);
                end
              end
              OP_READ: begin
                rd_data  <= mem[cmd_addr];
                rd_valid <= 1'b1;
              end
              OP_LOAD:   ldr <= mem[cmd_addr];
              OP_DELETE: mem[cmd_addr] <= '0;
              OP_SEARCH: begin
                if (!dsr_full) begin
                  srch_done <= 1'b1;
                  srch_hit  <= hit_any;
                  if (hit_any) begin
                    asr       <= hit_idx;
                    srch_addr <= hit_idx;
                  end else begin
                    dsr      <= cmd_data;
                    dsr_full <= 1'b1;
                  end
                end
              end
              OP_LEARN: begin
                if (dsr_full) begin
                  table_full <= 1'b0;
                  st         <= S_FIND;
                end
              end
              OP_SETWM: wmask <= cmd_data;
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cam_write_learn_chk.sv
module cam_write_learn_chk #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          cmd_ready,
  input logic          rd_valid,
  input logic          srch_done,
  input logic          srch_hit,
  input logic          dsr_full,
  input logic          table_full,
  input logic          learn_done
);
  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd2) |=> rd_valid); // R1
  AST_MISS_PARKS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && !srch_hit) |-> dsr_full); // R8
  AST_FULL_REFUSES_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd5 && dsr_full) |=> !srch_done); // R9
  AST_LEARN_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    learn_done |-> !dsr_full); // R10
  AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, srch_done, learn_done})); // R10
  AST_ABORT_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(table_full) |-> (dsr_full && cmd_ready)); // R11
endmodule

bind cam_write_learn cam_write_learn_chk #(.W(W), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .rd_valid(rd_valid), .srch_done(srch_done),
  .srch_hit(srch_hit), .dsr_full(dsr_full), .table_full(table_full),
  .learn_done(learn_done)
);

// File: tb/test_cam_write_learn.sv
module test_cam_write_learn;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, AW = 4;

  typedef struct packed {
    logic [2:0]  op;
    logic        asrc;
    logic [1:0]  dsrc;
    logic        pair;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [15:0] smask;
    logic [15:0] exp;   // read: data; search: {hit, done, .., addr}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{3'd7, 1'b0, 2'd0, 1'b0, 4'h0, 16'hFFFF, 16'h0000, 16'h0000, 4'd3},
    '{3'd1, 1'b0, 2'd0, 1'b0, 4'h2, 16'hA5A5, 16'h0000, 16'h0000, 4'd1},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h2, 16'h0000, 16'h0000, 16'hA5A5, 4'd1},  // R1
    '{3'd7, 1'b0, 2'd0, 1'b0, 4'h0, 16'h00FF, 16'h0000, 16'h0000, 4'd3},
    '{3'd1, 1'b0, 2'd0, 1'b0, 4'h2, 16'h1234, 16'h0000, 16'h0000, 4'd3},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h2, 16'h0000, 16'h0000, 16'hA534, 4'd3},  // R3
    '{3'd7, 1'b0, 2'd0, 1'b0, 4'h0, 16'hFFFF, 16'h0000, 16'h0000, 4'd3},
    '{3'd1, 1'b0, 2'd0, 1'b1, 4'hB, 16'h8001, 16'h0000, 16'h0000, 4'd4},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h3, 16'h0000, 16'h0000, 16'h8001, 4'd4},  // R4
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'hB, 16'h0000, 16'h0000, 16'h8001, 4'd4},  // R4
    '{3'd5, 1'b0, 2'd0, 1'b0, 4'h0, 16'h8001, 16'hFFFF, 16'hC003, 4'd5},  // R5
    '{3'd5, 1'b0, 2'd0, 1'b0, 4'h0, 16'h8000, 16'h8000, 16'hC002, 4'd5},  // R5
    '{3'd1, 1'b1, 2'd0, 1'b0, 4'h0, 16'h9999, 16'h0000, 16'h0000, 4'd2},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h2, 16'h0000, 16'h0000, 16'h9999, 4'd2},  // R2
    '{3'd3, 1'b0, 2'd0, 1'b0, 4'h2, 16'h0000, 16'h0000, 16'h0000, 4'd6},
    '{3'd4, 1'b0, 2'd0, 1'b0, 4'h2, 16'h0000, 16'h0000, 16'h0000, 4'd7},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h2, 16'h0000, 16'h0000, 16'h0000, 4'd7},  // R7
    '{3'd1, 1'b0, 2'd2, 1'b0, 4'h5, 16'h0000, 16'h0000, 16'h0000, 4'd6},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h5, 16'h0000, 16'h0000, 16'h9999, 4'd6},  // R6
    '{3'd5, 1'b0, 2'd0, 1'b0, 4'h0, 16'hC0DE, 16'hFFFF, 16'h4000, 4'd8},  // R8 miss
    '{3'd1, 1'b0, 2'd1, 1'b0, 4'h6, 16'h0000, 16'h0000, 16'h0000, 4'd8},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h6, 16'h0000, 16'h0000, 16'hC0DE, 4'd8},  // R8
    '{3'd5, 1'b0, 2'd0, 1'b0, 4'h0, 16'h9999, 16'hFFFF, 16'h0000, 4'd9},  // R9 refused
    '{3'd1, 1'b1, 2'd0, 1'b0, 4'h0, 16'h1111, 16'h0000, 16'h0000, 4'd9},
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h2, 16'h0000, 16'h0000, 16'h1111, 4'd9},  // R9
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h5, 16'h0000, 16'h0000, 16'h9999, 4'd9},  // R9
    '{3'd2, 1'b0, 2'd0, 1'b0, 4'h7, 16'h0000, 16'h0000, 16'h0000, 4'd12}  // R12
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_asrc = 1'b0, cmd_pair = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_dsrc = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [W-1:0] cmd_data = '0, srch_mask = '0;
  logic cmd_ready, rd_valid, srch_done, srch_hit, dsr_full, table_full, learn_done;
  logic [W-1:0] rd_data;
  logic [AW-1:0] srch_addr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_write_learn #(.W(W), .AW(AW)) i_cam_write_learn (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic asrc, input logic [1:0] dsrc,
                       input logic pair, input logic [3:0] addr, input logic [15:0] data,
                       input logic [15:0] smask);
    cmd_op = op; cmd_asrc = asrc; cmd_dsrc = dsrc; cmd_pair = pair;
    cmd_addr = addr; cmd_data = data; srch_mask = smask; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 ready", 32'(cmd_ready), 1);
    chk("R12 flags", {rd_valid, srch_done, learn_done, dsr_full, table_full}, 0);

    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].op, VECS[v].asrc, VECS[v].dsrc, VECS[v].pair,
            VECS[v].addr, VECS[v].data, VECS[v].smask);
      if (VECS[v].op == 3'd2) begin
        chk($sformatf("R%0d read v%0d", VECS[v].req, v), {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, VECS[v].exp});
      end else if (VECS[v].op == 3'd5) begin
        chk($sformatf("R%0d search-done v%0d", VECS[v].req, v), 32'(srch_done), 32'(VECS[v].exp[14]));
        if (VECS[v].exp[14]) begin
          chk($sformatf("R%0d search-hit v%0d", VECS[v].req, v), 32'(srch_hit), 32'(VECS[v].exp[15]));
          if (VECS[v].exp[15])
            chk($sformatf("R%0d search-addr v%0d", VECS[v].req, v), 32'(srch_addr), 32'(VECS[v].exp[3:0]));
        end
      end
    end
    chk("R8 full after miss", 32'(dsr_full), 1);

    // R4 paired write under a partial mask, halves with different old values
    issue(3'd1, 1'b0, 2'd0, 1'b0, 4'h4, 16'h1200, 16'h0);
    issue(3'd1, 1'b0, 2'd0, 1'b0, 4'hC, 16'h3400, 16'h0);
    issue(3'd7, 1'b0, 2'd0, 1'b0, 4'h0, 16'h00FF, 16'h0);
    issue(3'd1, 1'b0, 2'd0, 1'b1, 4'h4, 16'hFF77, 16'h0);
    issue(3'd2, 1'b0, 2'd0, 1'b0, 4'h4, 16'h0, 16'h0);
    chk("R4 pair low half", 32'(rd_data), 32'h1277);
    issue(3'd2, 1'b0, 2'd0, 1'b0, 4'hC, 16'h0, 16'h0);
    chk("R4 pair high half", 32'(rd_data), 32'h3477);
    // R7 delete ignores the mask
    issue(3'd4, 1'b0, 2'd0, 1'b0, 4'hC, 16'h0, 16'h0);
    issue(3'd2, 1'b0, 2'd0, 1'b0, 4'hC, 16'h0, 16'h0);
    chk("R7 delete under mask", 32'(rd_data), 0);
    issue(3'd7, 1'b0, 2'd0, 1'b0, 4'h0, 16'hFFFF, 16'h0);

    // R10 learn: lowest row with top bit 0 is row 0
    issue(3'd6, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0, 16'h0);
    chk("R10 busy", 32'(cmd_ready), 0);
    @(negedge clk);
    chk("R10 still busy", 32'(cmd_ready), 0);
    @(negedge clk);
    chk("R10 done", {learn_done, dsr_full, cmd_ready, table_full}, 4'b1010);
    issue(3'd2, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0, 16'h0);
    chk("R10 key written", 32'(rd_data), 32'hC0DE);
    issue(3'd1, 1'b1, 2'd0, 1'b0, 4'h9, 16'h8888, 16'h0);
    issue(3'd2, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0, 16'h0);
    chk("R10 address register holds learned row", 32'(rd_data), 32'h8888);

    // R11 table full: every row gets top bit 1
    for (int i = 0; i < 16; i++)
      issue(3'd1, 1'b0, 2'd0, 1'b0, 4'(i), 16'h8000 | 16'(i), 16'h0);
    issue(3'd5, 1'b0, 2'd0, 1'b0, 4'h0, 16'h7777, 16'hFFFF);
    chk("R11 miss parked", {srch_done, srch_hit, dsr_full}, 3'b101);
    issue(3'd6, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0, 16'h0);
    @(negedge clk);
    chk("R11 abort", {table_full, dsr_full, cmd_ready, learn_done}, 4'b1110);
    issue(3'd2, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0, 16'h0);
    chk("R11 array unchanged", 32'(rd_data), 32'h8000);
    issue(3'd4, 1'b0, 2'd0, 1'b0, 4'h5, 16'h0, 16'h0);
    issue(3'd6, 1'b0, 2'd0, 1'b0, 4'h0, 16'h0, 16'h0);
    chk("R11 status cleared on new learn", 32'(table_full), 0);
    repeat (2) @(negedge clk);
    issue(3'd2, 1'b0, 2'd0, 1'b0, 4'h5, 16'h0, 16'h0);
    chk("R11 retry writes key", 32'(rd_data), 32'h7777);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule